// File: doc/BRIEF.md
# Byte-Register PWM Generator with Auto-Off Timer

This block produces one active-high pulse-width-modulated output. The host programs it through a narrow write port that carries an address, a data byte and a write strobe. The period, the duty and the auto-off limit are each 16-bit values. Each value is split across a high-byte address and a low-byte address. A write to the high byte only fills a staging latch. A write to the low byte commits the staged byte and the new byte together as one word. Both period and duty are counted in pulses of `tick_en`, a clock enable that runs at 8 MHz (one pulse every 125 ns) in the target system.

The output goes high at the start of each period and stays high for the duty count. A committed period or duty does not change the running cycle; it is taken up at the next period boundary. The auto-off timer counts down in milliseconds, where one millisecond is `TICKS_PER_MS` ticks, and clears the enable when it runs out. The limit value 0xFFFF disables the timer. The block also models a known hazard: once a zero duty has been committed while the output is running, the output stays dead until the host turns the enable off and on again.

Top module: `bytereg_pwm`

## Requirements
- R1: After reset the output is low, the enable is 0, period, duty and all staging bytes are 0, and the auto-off limit is 0xFFFF.
- R2: A write to a high-byte address (0xA5 period, 0xA7 duty, 0xA1 auto-off) changes no committed value. A write to the matching low-byte address (0xA4, 0xA6, 0xA2) commits {staged high byte, written byte}.
- R3: While enabled with active period P>0 and active duty D, a counter advances on each `tick_en` and wraps from P-1 to 0. The output is high exactly while the counter is below D, so any window of k·P ticks holds k·D high ticks.
- R4: While enabled, a committed period or duty becomes active only at the next period boundary. While disabled, the counter sits at 0 and the committed values are loaded directly, so they are active as soon as the enable is set.
- R5: When the active duty is equal to or greater than the active period, the output is high for the whole cycle.
- R6: An active period of 0 holds the output low.
- R7: Address 0xA3 holds the enable in bit 0, and all other data bits are ignored. Writing 0 forces the output low and clears the counter. Writing 1 runs the generator.
- R8: Committing a duty of 0 while enabled sets a dead state. In this state the output stays low whatever duty follows. Only a write of 0 to the enable clears it.
- R9: When the auto-off limit is not 0xFFFF and the block is enabled, the remaining count drops by one every `TICKS_PER_MS` ticks. The cycle after the count reads 0, the enable is cleared. The count is reloaded when the auto-off low byte is committed, and also when the enable goes from 0 to 1.
- R10: With an auto-off limit of 0xFFFF the enable is never cleared by the timer.
- R11: A host write to 0xA3 in the same cycle as an expiry takes priority over the expiry. A commit of the auto-off low byte in the same cycle as a millisecond decrement takes priority over the decrement.
- R12: Writes to addresses outside 0xA1..0xA7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base enable, one pulse per counting tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | BYTE_W | Write data byte |
| pwm_out | output | 1 | PWM output, active high |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the auto-off expiry and a host write to the enable register. The bench commits a limit of 0 while the generator runs, so the expiry is due on the next edge, and writes enable=1 on exactly that edge. The host write must win, and the expiry must land one cycle later. The second pair is a low-byte reload and a millisecond decrement. Both meet when limits are rewritten during a long countdown. In both cases a behavioural model, compared on every clock, decides whether the output and its later shut-off moment are right.

// File: rtl/bytereg_pwm_pkg.sv
package bytereg_pwm_pkg;
   localparam logic [7:0] ADR_AUTO_HI = 8'hA1;
   localparam logic [7:0] ADR_AUTO_LO = 8'hA2;
   localparam logic [7:0] ADR_ENABLE  = 8'hA3;
   localparam logic [7:0] ADR_PER_LO  = 8'hA4;
   localparam logic [7:0] ADR_PER_HI  = 8'hA5;
   localparam logic [7:0] ADR_DUTY_LO = 8'hA6;
   localparam logic [7:0] ADR_DUTY_HI = 8'hA7;

   // slot numbering of the staged words
   localparam int SLOT_PER  = 0;
   localparam int SLOT_DUTY = 1;
   localparam int SLOT_AUTO = 2;
   localparam int NSLOT     = 3;

   function automatic logic [7:0] hi_addr(input int slot);
      case (slot)
         SLOT_PER:  return ADR_PER_HI;
         SLOT_DUTY: return ADR_DUTY_HI;
         default:   return ADR_AUTO_HI;
      endcase
   endfunction

   function automatic logic [7:0] lo_addr(input int slot);
      case (slot)
         SLOT_PER:  return ADR_PER_LO;
         SLOT_DUTY: return ADR_DUTY_LO;
         default:   return ADR_AUTO_LO;
      endcase
   endfunction
endpackage

// File: rtl/bpw_staged_word.sv
module bpw_staged_word #(
   parameter int                  BYTE_W  = 8,
   parameter logic [2*BYTE_W-1:0] RST_VAL = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hi_we,
   input  logic                  lo_we,
   input  logic [BYTE_W-1:0]     wdata,
   output logic [2*BYTE_W-1:0]   word_q,
   output logic [2*BYTE_W-1:0]   word_nx
);
   logic [BYTE_W-1:0] stage_q;

   assign word_nx = {stage_q, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         word_q  <= RST_VAL;
      end else begin
         if (hi_we) stage_q <= wdata;
         if (lo_we) word_q  <= word_nx;
      end
   end
endmodule

// File: rtl/bpw_autooff.sv
module bpw_autooff #(
   parameter int VAL_W        = 16,
   parameter int TICKS_PER_MS = 8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             en_q,
   input  logic             en_rise,
   input  logic [VAL_W-1:0] limit,
   input  logic             reload,
   input  logic [VAL_W-1:0] reload_val,
   output logic             expire
);
   localparam int MS_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
   localparam logic [MS_W-1:0] MS_LAST = MS_W'(TICKS_PER_MS - 1);

   logic [VAL_W-1:0] left_q;
   logic [MS_W-1:0]  ms_q;
   logic             armed;

   assign armed  = (limit != '1);
   assign expire = en_q && armed && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '1;
         ms_q   <= '0;
      end else if (reload) begin
         left_q <= reload_val;
         ms_q   <= '0;
      end else if (en_rise) begin
         left_q <= limit;
         ms_q   <= '0;
      end else if (en_q && armed && tick_en) begin
         if (ms_q == MS_LAST) begin
            ms_q <= '0;
            if (left_q != '0) left_q <= left_q - 1'b1;
         end else begin
            ms_q <= ms_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bpw_core.sv
module bpw_core #(
   parameter int VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             dead,
   input  logic [VAL_W-1:0] per_set,
   input  logic [VAL_W-1:0] duty_set,
   output logic             pwm_out
);
   logic [VAL_W-1:0] cnt_q;
   logic [VAL_W-1:0] per_act;
   logic [VAL_W-1:0] duty_act;
   logic             wrap;

   assign wrap = (per_act == '0) || (cnt_q == per_act - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         per_act  <= '0;
         duty_act <= '0;
      end else if (!run) begin
         cnt_q    <= '0;
         per_act  <= per_set;
         duty_act <= duty_set;
      end else if (tick_en) begin
         if (wrap) begin
            cnt_q    <= '0;
            per_act  <= per_set;
            duty_act <= duty_set;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pwm_out = run && !dead && (per_act != '0) && (cnt_q < duty_act);
endmodule

// File: rtl/bytereg_pwm.sv
module bytereg_pwm
   import bytereg_pwm_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int TICKS_PER_MS = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              pwm_out
);
   localparam int VAL_W = 2 * BYTE_W;

   if (BYTE_W < 2)       begin : g_bad_byte  $error("BYTE_W must be at least 2"); end
   if (TICKS_PER_MS < 1) begin : g_bad_ticks $error("TICKS_PER_MS must be positive"); end

   logic [VAL_W-1:0] word_q  [NSLOT];
   logic [VAL_W-1:0] word_nx [NSLOT];
   logic             lo_we   [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_word
      assign lo_we[s] = wr_en && (wr_addr == lo_addr(s));
      bpw_staged_word #(
         .BYTE_W  (BYTE_W),
         .RST_VAL ((s == SLOT_AUTO) ? {VAL_W{1'b1}} : {VAL_W{1'b0}})
      ) u_word (
         .clk     (clk),
         .rst_n   (rst_n),
         .hi_we   (wr_en && (wr_addr == hi_addr(s))),
         .lo_we   (lo_we[s]),
         .wdata   (wr_data),
         .word_q  (word_q[s]),
         .word_nx (word_nx[s])
      );
   end

   logic [VAL_W-1:0] per_q, duty_q, auto_q;
   logic             en_q, stuck_q, en_wr, en_rise, expire;

   assign per_q   = word_q[SLOT_PER];
   assign duty_q  = word_q[SLOT_DUTY];
   assign auto_q  = word_q[SLOT_AUTO];
   assign en_wr   = wr_en && (wr_addr == ADR_ENABLE);
   assign en_rise = en_wr && wr_data[0] && !en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         stuck_q <= 1'b0;
      end else begin
         if (en_wr)       en_q <= wr_data[0];
         else if (expire) en_q <= 1'b0;

         if (en_wr && !wr_data[0])
            stuck_q <= 1'b0;
         else if (lo_we[SLOT_DUTY] && en_q && (word_nx[SLOT_DUTY] == '0))
            stuck_q <= 1'b1;
      end
   end

   bpw_autooff #(.VAL_W(VAL_W), .TICKS_PER_MS(TICKS_PER_MS)) u_auto (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .en_q       (en_q),
      .en_rise    (en_rise),
      .limit      (auto_q),
      .reload     (lo_we[SLOT_AUTO]),
      .reload_val (word_nx[SLOT_AUTO]),
      .expire     (expire)
   );

   bpw_core #(.VAL_W(VAL_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .run      (en_q),
      .dead     (stuck_q),
      .per_set  (per_q),
      .duty_set (duty_q),
      .pwm_out  (pwm_out)
   );
endmodule

// File: rtl/bpw_checker.sv
module bpw_checker
   import bytereg_pwm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [7:0]            wr_addr,
   input logic [BYTE_W-1:0]     wr_data,
   input logic                  en_q,
   input logic                  stuck_q,
   input logic [2*BYTE_W-1:0]   per_q,
   input logic [2*BYTE_W-1:0]   duty_q,
   input logic [2*BYTE_W-1:0]   auto_q,
   input logic                  pwm_out
);
   a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !pwm_out);

   a_r8_dead_low: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_q |-> !pwm_out);

   a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_ENABLE && !wr_data[0]) |=> (!en_q && !pwm_out));

   a_r2_hi_stages: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADR_PER_HI || wr_addr == ADR_DUTY_HI || wr_addr == ADR_AUTO_HI))
      |=> ($stable(per_q) && $stable(duty_q) && $stable(auto_q)));

   a_r10_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && auto_q == '1 && !(wr_en && wr_addr == ADR_ENABLE)) |=> en_q);

   a_r11_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_ENABLE && wr_data[0]) |=> en_q);

   a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr < ADR_AUTO_HI || wr_addr > ADR_DUTY_HI))
      |=> ($stable(per_q) && $stable(duty_q) && $stable(auto_q)));
endmodule

bind bytereg_pwm bpw_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .en_q    (en_q),
   .stuck_q (stuck_q),
   .per_q   (per_q),
   .duty_q  (duty_q),
   .auto_q  (auto_q),
   .pwm_out (pwm_out)
);

// File: tb/bytereg_pwm_tb_top.sv
module bytereg_pwm_tb_top;
   localparam int TPM = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       pwm_out;

   int n_cmp = 0;
   int n_bad = 0;
   int tick_div = 1;
   bit done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   bytereg_pwm #(.BYTE_W(8), .TICKS_PER_MS(TPM)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
   );

   // time base
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         tick_en = (ph == 0);
         ph = (ph + 1) % tick_div;
      end
   end

   // behavioural reference model
   int m_stg [3];
   int m_val [3];
   int m_en = 0, m_dead = 0, m_cnt = 0, m_per = 0, m_duty = 0, m_left = 65535, m_ms = 0;

   initial begin
      for (int i = 0; i < 3; i++) begin m_stg[i] = 0; m_val[i] = 0; end
      m_val[2] = 65535;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin m_stg[i] = 0; m_val[i] = 0; end
         m_val[2] = 65535;
         m_en = 0; m_dead = 0; m_cnt = 0; m_per = 0; m_duty = 0; m_left = 65535; m_ms = 0;
      end else begin
         int slot, is_hi, is_lo, d, n_cnt, n_per, n_duty, n_left, n_ms, n_en, n_dead, fire;
         d = int'(wr_data);
         slot = -1; is_hi = 0; is_lo = 0;
         if (wr_en) begin
            case (wr_addr)
               8'hA4: begin slot = 0; is_lo = 1; end
               8'hA5: begin slot = 0; is_hi = 1; end
               8'hA6: begin slot = 1; is_lo = 1; end
               8'hA7: begin slot = 1; is_hi = 1; end
               8'hA2: begin slot = 2; is_lo = 1; end
               8'hA1: begin slot = 2; is_hi = 1; end
               default: slot = -1;
            endcase
         end
         fire = (m_en != 0 && m_val[2] != 65535 && m_left == 0);
         n_cnt = m_cnt; n_per = m_per; n_duty = m_duty;
         if (m_en == 0) begin
            n_cnt = 0; n_per = m_val[0]; n_duty = m_val[1];
         end else if (tick_en) begin
            if (m_per == 0 || m_cnt == m_per - 1) begin
               n_cnt = 0; n_per = m_val[0]; n_duty = m_val[1];
            end else n_cnt = m_cnt + 1;
         end
         n_left = m_left; n_ms = m_ms;
         if (is_lo && slot == 2) begin
            n_left = m_stg[2] * 256 + d; n_ms = 0;
         end else if (wr_en && wr_addr == 8'hA3 && d % 2 == 1 && m_en == 0) begin
            n_left = m_val[2]; n_ms = 0;
         end else if (m_en != 0 && m_val[2] != 65535 && tick_en) begin
            if (m_ms == TPM - 1) begin
               n_ms = 0;
               if (m_left != 0) n_left = m_left - 1;
            end else n_ms = m_ms + 1;
         end
         n_en = m_en;
         if (wr_en && wr_addr == 8'hA3) n_en = d % 2;
         else if (fire) n_en = 0;
         n_dead = m_dead;
         if (wr_en && wr_addr == 8'hA3 && d % 2 == 0) n_dead = 0;
         else if (is_lo && slot == 1 && m_en != 0 && m_stg[1] * 256 + d == 0) n_dead = 1;
         if (is_lo) m_val[slot] = m_stg[slot] * 256 + d;
         if (is_hi) m_stg[slot] = d;
         m_cnt = n_cnt; m_per = n_per; m_duty = n_duty; m_left = n_left; m_ms = n_ms;
         m_en = n_en; m_dead = n_dead;
      end
   end

   function automatic bit model_out();
      return (m_en != 0) && (m_dead == 0) && (m_per != 0) && (m_cnt < m_duty);
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (pwm_out !== model_out()) begin
            n_bad++;
            $display("FAIL %s: pwm_out actual %0b expected %0b at %0t", cur_req, pwm_out, model_out(), $time);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input int n, input int exp_hi, input string req);
      int hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_out === 1'b1) hi++;
      end
      n_cmp++;
      if (hi != exp_hi) begin
         n_bad++;
         $display("FAIL %s: high count actual %0d expected %0d", req, hi, exp_hi);
      end
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            if (!done) begin
               n_bad++;
               $display("FAIL watchdog: run actual hung expected finished");
               done = 1'b1;
               $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
               $finish;
            end
         end
      join_none
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      measure(5, 0, "R1");
      // R3: period 10, duty 3
      cur_req = "R3";
      wr(8'hA5, 8'h00); wr(8'hA4, 8'd10);
      wr(8'hA7, 8'h00); wr(8'hA6, 8'd3);
      wr(8'hA3, 8'h01);
      idle(7);
      measure(30, 9, "R3");
      // R2: staging duty high byte only
      cur_req = "R2";
      wr(8'hA7, 8'h01);
      idle(12);
      measure(30, 9, "R2");
      // R5: commit 0x0100 duty, larger than period
      cur_req = "R5";
      wr(8'hA6, 8'h00);
      idle(12);
      measure(20, 20, "R5");
      // R4: change duty, takes effect at boundary
      cur_req = "R4";
      wr(8'hA7, 8'h00); wr(8'hA6, 8'd7);
      idle(12);
      measure(30, 21, "R4");
      // R6: period 0
      cur_req = "R6";
      wr(8'hA4, 8'd0);
      idle(12);
      measure(20, 0, "R6");
      wr(8'hA4, 8'd10);
      idle(12);
      // R7: enable bit 0 only
      cur_req = "R7";
      wr(8'hA3, 8'hFE);
      measure(20, 0, "R7");
      wr(8'hA3, 8'h03);
      measure(30, 21, "R7");
      // R8: zero duty while enabled
      cur_req = "R8";
      wr(8'hA6, 8'd0);
      wr(8'hA6, 8'd5);
      idle(12);
      measure(20, 0, "R8");
      wr(8'hA3, 8'h00); wr(8'hA3, 8'h01);
      measure(30, 15, "R8");
      // R12: unmapped addresses
      cur_req = "R12";
      wr(8'hA0, 8'h00); wr(8'hA8, 8'h00); wr(8'h24, 8'h00);
      measure(30, 15, "R12");
      // R9: auto-off 3 ms
      cur_req = "R9";
      wr(8'hA1, 8'h00); wr(8'hA2, 8'd3);
      measure(30, 15, "R9");
      idle(50);
      measure(20, 0, "R9");
      wr(8'hA3, 8'h01);
      measure(30, 15, "R9");
      idle(60);
      // R11: expiry collides with host enable write
      cur_req = "R11";
      wr(8'hA3, 8'h00); wr(8'hA3, 8'h01);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'hA2; wr_data = 8'd0;
      @(negedge clk);
      wr_addr = 8'hA3; wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      idle(2);
      measure(20, 0, "R11");
      // R11: reload racing decrements with slow ticks
      tick_div = 3;
      wr(8'hA2, 8'd2); wr(8'hA3, 8'h00); wr(8'hA3, 8'h01);
      for (int k = 0; k < 6; k++) begin
         idle(TPM * 3 - 1);
         wr(8'hA2, 8'd2);
      end
      idle(400);
      measure(20, 0, "R11");
      tick_div = 1;
      // R10: auto-off disabled
      cur_req = "R10";
      wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
      wr(8'hA3, 8'h01);
      idle(300);
      measure(30, 15, "R10");
      // R3 with gated ticks, period 4 duty 1
      cur_req = "R3";
      tick_div = 3;
      wr(8'hA4, 8'd4); wr(8'hA6, 8'd1);
      idle(60);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule